// File: doc/BRIEF.md
# Indexed CMOS Register Port

This block is a 128-byte register file reached through a narrow two-location host window. One location holds a 7-bit pointer into the file. The other location reads or writes the byte that the pointer selects. Four of the bytes are clock-control and status registers that the time-keeping logic uses. For these four, the data location applies special rules: some bits are protected, a status byte clears itself when it is read, and a write that enters set mode has side effects. Everything else in the file is plain storage.

The time-keeping and rate-generation blocks stay outside. They reach the block through sideband pins. A one-cycle flag mask sets bits in the status byte and raises the interrupt line, and a pair of strobes drives the update-in-progress bit. A sideband configuration write port lets firmware load bytes directly. When it writes a byte in the configuration range, the block recomputes a 16-bit additive checksum over that range, one byte per clock. The finished sum is written back into the file.

Host accesses use a valid/ready request channel. `req_ready` is low for as long as the checksum walk runs, and a request is taken only in a cycle where `req_valid` and `req_ready` are both high. Every accepted read returns its byte on `rsp_rdata` together with a one-cycle `rsp_valid` pulse, one clock after acceptance. The response channel cannot be back-pressured.

Top module: `cmos_regport`

## Requirements
- R1: An accepted write with `req_sel`=0 loads the pointer with `req_wdata[6:0]`, and bit 7 is dropped.
- R2: An accepted read with `req_sel`=0 returns 0xFF.
- R3: An accepted data access (`req_sel`=1) writes or reads the byte at the pointer. A read returns its byte with `rsp_valid` high exactly one clock after acceptance.
- R4: Host writes to index 12 (status) and index 13 are ignored. Index 13 always reads 0x80.
- R5: A host read of index 12 returns the value it held before the read. The register is then 0x00 and `irq` is low, unless a flag set arrives in that same cycle.
- R6: Bit 7 of index 10 (update in progress) cannot be changed by host writes. A host write to index 10 keeps the old bit 7 and takes bits 6:0 from the data. `uip_set` sets the bit and `uip_clr` clears it.
- R7: A host write to index 11 with bit 7 = 1 stores the data with bit 4 forced to 0, and clears bit 7 of index 10. With bit 7 = 0, the data is stored unchanged.
- R8: After reset, index 10 = 0x26, index 11 = 0x02, index 12 = 0x00, index 13 = 0x80, `irq` = 0, `sum_busy` = 0, and the plain bytes read 0x00.
- R9: A nonzero `flag_set` ORs its bits into index 12 and raises `irq`. When it coincides with a clear-on-read, the set bits and `irq` survive.
- R10: The 16-bit sum of bytes 0x10..0x2D is written with its high byte at 0x2E and its low byte at 0x2F. A recompute starts on a sideband write into 0x10..0x2D, and only on such a write. Host writes and sideband writes outside that range start nothing.
- R11: A recompute keeps `sum_busy` high for (0x2D-0x10+2) = 31 cycles: one cycle per byte plus one write-back cycle. `req_ready` is low for that whole time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Host request accepted when high; low during checksum walk |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sel | input | 1 | 0 = pointer location, 1 = data location |
| req_wdata | input | 8 | Host write data |
| rsp_valid | output | 1 | Read response valid, one cycle after read acceptance |
| rsp_rdata | output | 8 | Read response data |
| cfg_we | input | 1 | Sideband configuration write strobe |
| cfg_addr | input | 7 | Sideband byte address |
| cfg_wdata | input | 8 | Sideband write data |
| flag_set | input | 8 | One-cycle mask ORed into status index 12; nonzero raises irq |
| uip_set | input | 1 | Sets update-in-progress bit |
| uip_clr | input | 1 | Clears update-in-progress bit |
| ctl_a | output | 8 | Current index-10 control byte |
| ctl_b | output | 8 | Current index-11 control byte |
| irq | output | 1 | Interrupt request |
| sum_busy | output | 1 | Checksum recompute in progress |

## Verification
The assertions run on every cycle. They check that a clear-on-read without a coinciding set leaves the status byte and the interrupt at zero, and that any flag set is visible the next cycle. They also check that the protected bit survives a host write, that a set-mode write clears the enable and progress bits, and that a response pulse appears only after an accepted read. On the checksum side, they check that the walk pointer stays inside the summed range and that a host write can never meet a sum write-back. The bench scenarios are what show the checksum's actual value with carries into the high byte and the exact 31-cycle busy window. They also show that host and out-of-range sideband writes start no recompute, that writes to the status bytes are ignored, and that the 7-bit pointer truncation behaves as required.

// File: rtl/cmos_pkg.sv
package cmos_pkg;
  localparam int unsigned IDX_CTLA = 10;
  localparam int unsigned IDX_CTLB = 11;
  localparam int unsigned IDX_STAT = 12;
  localparam int unsigned IDX_FIXD = 13;
  localparam logic [7:0]  RST_CTLA = 8'h26;
  localparam logic [7:0]  RST_CTLB = 8'h02;
  localparam logic [7:0]  VAL_FIXD = 8'h80;
  localparam int unsigned UIP_BIT  = 7;
  localparam int unsigned SET_BIT  = 7;
  localparam int unsigned UEIE_BIT = 4;
  typedef enum logic [1:0] {SW_IDLE, SW_WALK, SW_WB} sw_state_e;
endpackage

// File: rtl/cmos_index_reg.sv
module cmos_index_reg #(
  parameter int unsigned AW = 7,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [DW-1:0] wdata,
  output logic [AW-1:0] idx
);
  always_ff @(posedge clk) begin
    if (!rst_n)  idx <= '0;
    else if (ld) idx <= wdata[AW-1:0];
  end

  a_r1_load_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> idx == $past(wdata[AW-1:0]));
endmodule

// File: rtl/cmos_ctrl_regs.sv
module cmos_ctrl_regs
  import cmos_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_a,
  input  logic          wr_b,
  input  logic          rd_c,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] flag_set,
  input  logic          uip_set,
  input  logic          uip_clr,
  output logic [DW-1:0] reg_a,
  output logic [DW-1:0] reg_b,
  output logic [DW-1:0] reg_c,
  output logic          irq
);
  logic [DW-1:0] a_n, b_n, c_n;
  logic          irq_n;
  logic          enter_set;

  assign enter_set = wr_b && wdata[SET_BIT];

  always_comb begin
    a_n = reg_a;
    if (uip_set) a_n[UIP_BIT] = 1'b1;
    if (uip_clr) a_n[UIP_BIT] = 1'b0;
    if (wr_a)    a_n = {a_n[UIP_BIT], wdata[DW-2:0]};
    if (enter_set) a_n[UIP_BIT] = 1'b0;
  end

  always_comb begin
    b_n = reg_b;
    if (wr_b) begin
      b_n = wdata;
      if (enter_set) b_n[UEIE_BIT] = 1'b0;
    end
  end

  always_comb begin
    c_n   = (rd_c ? '0 : reg_c) | flag_set;
    irq_n = irq;
    if (rd_c)          irq_n = 1'b0;
    if (|flag_set)     irq_n = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_a <= RST_CTLA[DW-1:0];
      reg_b <= RST_CTLB[DW-1:0];
      reg_c <= '0;
      irq   <= 1'b0;
    end else begin
      reg_a <= a_n;
      reg_b <= b_n;
      reg_c <= c_n;
      irq   <= irq_n;
    end
  end

  a_r5_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_c && flag_set == '0) |=> (reg_c == '0 && !irq));
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_set != '0) |=> (irq && ((reg_c & $past(flag_set)) == $past(flag_set))));
  a_r6_uip_protected: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_a && !wr_b && !uip_set && !uip_clr) |=> reg_a[UIP_BIT] == $past(reg_a[UIP_BIT]));
  a_r7_set_mode: assert property (@(posedge clk) disable iff (!rst_n)
    enter_set |=> (!reg_b[UEIE_BIT] && !reg_a[UIP_BIT] && reg_b[SET_BIT]));
endmodule

// File: rtl/cmos_byte_store.sv
module cmos_byte_store #(
  parameter int unsigned DW     = 8,
  parameter int unsigned DEPTH  = 128,
  parameter int unsigned AW     = 7,
  parameter int unsigned HI_IDX = 46,
  parameter int unsigned LO_IDX = 47
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [AW-1:0]   cfg_addr,
  input  logic [DW-1:0]   cfg_wdata,
  input  logic            host_we,
  input  logic [AW-1:0]   host_addr,
  input  logic [DW-1:0]   host_wdata,
  input  logic            sum_we,
  input  logic [2*DW-1:0] sum_val,
  input  logic [AW-1:0]   rd_addr_a,
  output logic [DW-1:0]   rd_data_a,
  input  logic [AW-1:0]   rd_addr_b,
  output logic [DW-1:0]   rd_data_b
);
  logic [DEPTH*DW-1:0] flat;

  for (genvar g = 0; g < DEPTH; g++) begin : g_byte
    localparam bit IS_HI = (g == HI_IDX);
    localparam bit IS_LO = (g == LO_IDX);
    logic [DW-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)                                   q <= '0;
      else if (cfg_we && cfg_addr == AW'(g))        q <= cfg_wdata;
      else if (host_we && host_addr == AW'(g))      q <= host_wdata;
      else if (sum_we && IS_HI)                     q <= sum_val[2*DW-1:DW];
      else if (sum_we && IS_LO)                     q <= sum_val[DW-1:0];
    end
    assign flat[g*DW +: DW] = q;
  end

  assign rd_data_a = flat[rd_addr_a*DW +: DW];
  assign rd_data_b = flat[rd_addr_b*DW +: DW];

  a_r11_no_host_during_wb: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_we && sum_we));
endmodule

// File: rtl/cmos_sum_walker.sv
module cmos_sum_walker
  import cmos_pkg::*;
#(
  parameter int unsigned DW    = 8,
  parameter int unsigned AW    = 7,
  parameter int unsigned FIRST = 16,
  parameter int unsigned LAST  = 45
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trig,
  output logic [AW-1:0]   rd_addr,
  input  logic [DW-1:0]   rd_data,
  output logic            wb_en,
  output logic [2*DW-1:0] wb_sum,
  output logic            busy
);
  localparam logic [AW-1:0] P_FIRST = AW'(FIRST);
  localparam logic [AW-1:0] P_LAST  = AW'(LAST);

  sw_state_e       state;
  logic [AW-1:0]   ptr;
  logic [2*DW-1:0] acc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= SW_IDLE;
      ptr   <= P_FIRST;
      acc   <= '0;
    end else if (trig) begin
      state <= SW_WALK;
      ptr   <= P_FIRST;
      acc   <= '0;
    end else begin
      case (state)
        SW_WALK: begin
          acc <= acc + {{DW{1'b0}}, rd_data};
          if (ptr == P_LAST) state <= SW_WB;
          else               ptr   <= ptr + 1'b1;
        end
        SW_WB:   state <= SW_IDLE;
        default: state <= SW_IDLE;
      endcase
    end
  end

  assign rd_addr = ptr;
  assign wb_en   = (state == SW_WB);
  assign wb_sum  = acc;
  assign busy    = (state != SW_IDLE);

  a_r11_ptr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SW_WALK) |-> (ptr >= P_FIRST && ptr <= P_LAST));
  a_r10_single_writeback: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |=> !wb_en);
endmodule

// File: rtl/cmos_regport.sv
module cmos_regport
  import cmos_pkg::*;
#(
  parameter int unsigned DW        = 8,
  parameter int unsigned DEPTH     = 128,
  parameter int unsigned SUM_FIRST = 16,
  parameter int unsigned SUM_LAST  = 45,
  parameter int unsigned SUM_HI    = 46,
  parameter int unsigned SUM_LO    = 47
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic                     req_sel,
  input  logic [DW-1:0]            req_wdata,
  output logic                     rsp_valid,
  output logic [DW-1:0]            rsp_rdata,
  input  logic                     cfg_we,
  input  logic [$clog2(DEPTH)-1:0] cfg_addr,
  input  logic [DW-1:0]            cfg_wdata,
  input  logic [DW-1:0]            flag_set,
  input  logic                     uip_set,
  input  logic                     uip_clr,
  output logic [DW-1:0]            ctl_a,
  output logic [DW-1:0]            ctl_b,
  output logic                     irq,
  output logic                     sum_busy
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam logic [AW-1:0] I_A = AW'(IDX_CTLA);
  localparam logic [AW-1:0] I_B = AW'(IDX_CTLB);
  localparam logic [AW-1:0] I_C = AW'(IDX_STAT);
  localparam logic [AW-1:0] I_D = AW'(IDX_FIXD);
  localparam logic [AW-1:0] S_FIRST = AW'(SUM_FIRST);
  localparam logic [AW-1:0] S_LAST  = AW'(SUM_LAST);

  logic            accept, idx_ld, data_we, data_rd, is_ctrl;
  logic [AW-1:0]   idx;
  logic [DW-1:0]   reg_c, store_rd, sel_byte, walk_byte;
  logic [AW-1:0]   walk_addr;
  logic            wb_en, trig;
  logic [2*DW-1:0] wb_sum;

  assign req_ready = !sum_busy;
  assign accept    = req_valid && req_ready;
  assign idx_ld    = accept && req_write && !req_sel;
  assign data_we   = accept && req_write && req_sel;
  assign data_rd   = accept && !req_write && req_sel;
  assign is_ctrl   = (idx == I_A) || (idx == I_B) || (idx == I_C) || (idx == I_D);
  assign trig      = cfg_we && (cfg_addr >= S_FIRST) && (cfg_addr <= S_LAST);

  cmos_index_reg #(.AW(AW), .DW(DW)) u_idx (
    .clk(clk), .rst_n(rst_n), .ld(idx_ld), .wdata(req_wdata), .idx(idx)
  );

  cmos_ctrl_regs #(.DW(DW)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .wr_a(data_we && idx == I_A),
    .wr_b(data_we && idx == I_B),
    .rd_c(data_rd && idx == I_C),
    .wdata(req_wdata), .flag_set(flag_set),
    .uip_set(uip_set), .uip_clr(uip_clr),
    .reg_a(ctl_a), .reg_b(ctl_b), .reg_c(reg_c), .irq(irq)
  );

  cmos_byte_store #(.DW(DW), .DEPTH(DEPTH), .AW(AW),
                    .HI_IDX(SUM_HI), .LO_IDX(SUM_LO)) u_store (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .host_we(data_we && !is_ctrl), .host_addr(idx), .host_wdata(req_wdata),
    .sum_we(wb_en), .sum_val(wb_sum),
    .rd_addr_a(idx), .rd_data_a(store_rd),
    .rd_addr_b(walk_addr), .rd_data_b(walk_byte)
  );

  cmos_sum_walker #(.DW(DW), .AW(AW), .FIRST(SUM_FIRST), .LAST(SUM_LAST)) u_walk (
    .clk(clk), .rst_n(rst_n), .trig(trig),
    .rd_addr(walk_addr), .rd_data(walk_byte),
    .wb_en(wb_en), .wb_sum(wb_sum), .busy(sum_busy)
  );

  always_comb begin
    if      (idx == I_A) sel_byte = ctl_a;
    else if (idx == I_B) sel_byte = ctl_b;
    else if (idx == I_C) sel_byte = reg_c;
    else if (idx == I_D) sel_byte = VAL_FIXD[DW-1:0];
    else                 sel_byte = store_rd;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= accept && !req_write;
      if (accept && !req_write) rsp_rdata <= req_sel ? sel_byte : {DW{1'b1}};
    end
  end

  a_r3_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && req_ready && !req_write));
  a_r11_stall_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (sum_busy && req_valid) |=> !rsp_valid || $past(!req_write) == 1'b0);
endmodule

// File: tb/sim_cmos_regport.sv
module sim_cmos_regport;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_sel = 1'b0;
  logic [7:0] req_wdata = '0;
  logic req_ready, rsp_valid, irq, sum_busy;
  logic [7:0] rsp_rdata, ctl_a, ctl_b;
  logic cfg_we = 1'b0;
  logic [6:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] flag_set = '0;
  logic uip_set = 1'b0, uip_clr = 1'b0;

  int n_run = 0, n_fail = 0;
  int m_mem[128];

  always #10 clk = ~clk;

  cmos_regport u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_sel(req_sel), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .flag_set(flag_set), .uip_set(uip_set), .uip_clr(uip_clr),
    .ctl_a(ctl_a), .ctl_b(ctl_b), .irq(irq), .sum_busy(sum_busy)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_sel = sel; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic host_rd(input logic sel, output logic [7:0] d, output logic v);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_sel = sel;
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_rdata; v = rsp_valid;
  endtask

  task automatic rd_at(input int index, output logic [7:0] d);
    logic v;
    host_wr(1'b0, 8'(index));
    host_rd(1'b1, d, v);
  endtask

  task automatic wr_at(input int index, input logic [7:0] d);
    host_wr(1'b0, 8'(index));
    host_wr(1'b1, d);
    if (index < 10 || index > 13) m_mem[index] = d;
  endtask

  task automatic cfg_wr(input int a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 7'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    m_mem[a] = d;
  endtask

  function automatic int model_sum();
    int s = 0;
    for (int i = 16; i <= 45; i++) s += m_mem[i];
    return s & 16'hFFFF;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic v;
    int n;
    for (int i = 0; i < 128; i++) m_mem[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    chk("R8 ctl_a", ctl_a, 8'h26);
    chk("R8 ctl_b", ctl_b, 8'h02);
    chk("R8 irq", irq, 0);
    chk("R8 busy", sum_busy, 0);
    rd_at(12, d); chk("R8 stat", d, 8'h00);
    rd_at(13, d); chk("R8 fixed", d, 8'h80);
    rd_at(70, d); chk("R8 plain byte", d, 8'h00);

    // R2 pointer location reads 0xFF
    host_rd(1'b0, d, v);
    chk("R2 ptr read", d, 8'hFF);
    chk("R3 rsp_valid", v, 1);

    // R1 / R3 pointer truncation and data access
    host_wr(1'b0, 8'hC5);
    host_wr(1'b1, 8'h5A); m_mem[8'h45] = 8'h5A;
    rd_at(8'h45, d); chk("R1 truncated index", d, 8'h5A);
    wr_at(3, 8'h17);
    rd_at(3, d); chk("R3 data rw", d, 8'h17);
    @(negedge clk); chk("R3 single pulse", rsp_valid, 0);

    // R9 / R5 flag set and clear-on-read
    @(negedge clk); flag_set = 8'h40;
    @(negedge clk); flag_set = 8'h00;
    chk("R9 irq raised", irq, 1);
    rd_at(12, d); chk("R5 read value", d, 8'h40);
    chk("R5 irq cleared", irq, 0);
    rd_at(12, d); chk("R5 cleared", d, 8'h00);

    // R9 set wins over clear-on-read in the same cycle
    host_wr(1'b0, 8'd12);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_sel = 1'b1; flag_set = 8'h20;
    @(negedge clk);
    req_valid = 1'b0; flag_set = 8'h00;
    chk("R9 old value returned", rsp_rdata, 8'h00);
    chk("R9 irq kept", irq, 1);
    rd_at(12, d); chk("R9 set bit kept", d, 8'h20);

    // R4 writes to status and fixed byte ignored
    wr_at(12, 8'hFF);
    chk("R4 irq untouched", irq, 0);
    rd_at(12, d); chk("R4 stat ignored", d, 8'h00);
    wr_at(13, 8'h00);
    rd_at(13, d); chk("R4 fixed ignored", d, 8'h80);

    // R6 protected progress bit
    @(negedge clk); uip_set = 1'b1;
    @(negedge clk); uip_set = 1'b0;
    chk("R6 uip set", ctl_a, 8'hA6);
    wr_at(10, 8'h05);
    chk("R6 bit7 kept on write", ctl_a, 8'h85);
    @(negedge clk); uip_clr = 1'b1;
    @(negedge clk); uip_clr = 1'b0;
    chk("R6 uip clr", ctl_a, 8'h05);
    wr_at(10, 8'hFA);
    chk("R6 bit7 stays 0", ctl_a, 8'h7A);

    // R7 set mode entry
    @(negedge clk); uip_set = 1'b1;
    @(negedge clk); uip_set = 1'b0;
    wr_at(11, 8'h92);
    chk("R7 enable forced off", ctl_b, 8'h82);
    chk("R7 uip cleared", ctl_a, 8'h7A);
    wr_at(11, 8'h12);
    chk("R7 no set mode", ctl_b, 8'h12);
    rd_at(11, d); chk("R7 read back", d, 8'h12);

    // R10 host write in range and sideband outside range start nothing
    wr_at(8'h20, 8'h33);
    chk("R10 host no trigger", sum_busy, 0);
    cfg_wr(8'h40, 8'h99);
    chk("R10 cfg outside no trigger", sum_busy, 0);
    rd_at(8'h2F, d); chk("R10 sum untouched", d, 8'h00);
    rd_at(8'h40, d); chk("R10 cfg stored", d, 8'h99);

    // R11 busy length and R10 value
    cfg_wr(8'h10, 8'hFF);
    n = 0;
    chk("R11 ready low", req_ready, 0);
    while (sum_busy && n < 100) begin n++; @(negedge clk); end
    chk("R11 busy cycles", n, 31);
    cfg_wr(8'h2D, 8'hFF);
    cfg_wr(8'h1A, 8'h7E);
    rd_at(8'h2E, d); chk("R10 sum high", d, (model_sum() >> 8) & 8'hFF);
    rd_at(8'h2F, d); chk("R10 sum low", d, model_sum() & 8'hFF);
    for (int i = 16; i <= 45; i++) m_mem[i] = 8'hFF;
    for (int i = 16; i <= 45; i++) cfg_wr(i, 8'hFF);
    rd_at(8'h2E, d); chk("R10 full high", d, (model_sum() >> 8) & 8'hFF);
    rd_at(8'h2F, d); chk("R10 full low", d, model_sum() & 8'hFF);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule